// File: doc/BRIEF.md
# Reservation Unit for Conditional Atomic Stores

This block gives one processor a reserve-then-conditionally-store atomic primitive on a shared, snooped memory bus. A reserving load records the cache line of the requested address in a single reservation slot and arms it. It also issues an ordinary memory read. A later conditional store is allowed to reach memory only if the slot is still armed and the store falls in the same line. The block reports the outcome on a status output.

The unit watches stores that other agents place on the bus. A store that lands anywhere in the reserved line disarms the slot. A successful conditional store leaves as a plain memory write on the bus. The other processors' units see that write as a snooped store and drop their own reservations on that line, so several processors may hold a reservation on the same line at once. Every result is registered and appears one cycle after the request.

Top module: `resv_unit`

## Requirements
- R1: While reset is held, `sc_done`, `sc_ok`, `mem_we` and `mem_rd` are low on the next clock, and the slot is disarmed, so a first conditional store fails.
- R2: `cpu_op` = 1 is a reserving load. One cycle later, `mem_rd` is high and `mem_addr` equals the request address. The slot is armed with that address's line.
- R3: `cpu_op` = 2 is a conditional store. If the slot is armed on the same line, then one cycle later `sc_done`, `sc_ok` and `mem_we` are high, and `mem_addr`/`mem_wdata` carry the request.
- R4: A conditional store with the slot disarmed gives `sc_done` high, `sc_ok` low and `mem_we` low one cycle later.
- R5: A conditional store to a line other than the reserved one fails in the same way.
- R6: Lines are 2^LINE_OFF_W bytes. Address bits below LINE_OFF_W are ignored in every comparison, so a conditional store to another offset in the reserved line succeeds.
- R7: Every conditional store disarms the slot, whether it passes or fails.
- R8: A snooped store (`snp_valid` high) to any address in the reserved line disarms the slot. A snooped store to another line leaves the slot armed.
- R9: If a snooped store hits the reserved line in the same cycle as a conditional store to it, the conditional store fails.
- R10: If a reserving load and a snooped store to the same line arrive in the same cycle, the slot ends up armed.
- R11: A new reserving load replaces the reserved line.
- R12: `cpu_op` = 0 is idle. One cycle later, `sc_done`, `mem_we` and `mem_rd` are low. `mem_we` is never high without `sc_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_op | input | 2 | Request: 0 idle, 1 reserving load, 2 conditional store |
| cpu_addr | input | ADDR_W | Request byte address |
| cpu_wdata | input | DATA_W | Conditional store data |
| snp_valid | input | 1 | Another agent's store is on the bus this cycle |
| snp_addr | input | ADDR_W | Address of the snooped store |
| sc_done | output | 1 | Conditional store outcome valid |
| sc_ok | output | 1 | Conditional store succeeded |
| mem_rd | output | 1 | Memory read for a reserving load |
| mem_we | output | 1 | Memory write, also seen by other snoopers |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |

## Verification
A snooped store can land on the reserved line in the same cycle that the processor issues a conditional store to it, or in the same cycle as a fresh reserving load. The bench drives `snp_valid` and the processor request together in one cycle for both cases. It then judges the outcome in two ways: it checks `sc_ok`/`mem_we` on the following cycle, and it issues a later conditional store to probe whether the slot is still armed. The expected outcomes come from the bench's own slot model, which lets the snoop win against a conditional store and lose against a reserving load.

// File: rtl/resv_pkg.sv
// Shared request encoding for the reservation unit.
package resv_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RESV = 2'd1,
        OP_COND = 2'd2
    } resv_op_e;
endpackage

// File: rtl/resv_line_match.sv
// Extracts the line number of a byte address and compares it with a
// reference line. Assumes lines of 2**LINE_OFF_W bytes.
module resv_line_match #(
    parameter int ADDR_W     = 32,
    parameter int LINE_OFF_W = 6,
    localparam int TAG_W     = ADDR_W - LINE_OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [TAG_W-1:0]  ref_tag,
    output logic [TAG_W-1:0]  tag,
    output logic              same
);
    logic unused_offset;

    // Split off the line number and compare it.
    always_comb begin
        tag           = addr[ADDR_W-1:LINE_OFF_W];
        same          = (tag == ref_tag);
        unused_offset = ^addr[LINE_OFF_W-1:0];
    end
endmodule

// File: rtl/resv_slot.sv
// Single reservation slot: an armed flag and a line number.
// Assumes arm and disarm may coincide; arming wins.
module resv_slot #(
    parameter int TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [TAG_W-1:0] arm_tag,
    input  logic             disarm,
    output logic             armed,
    output logic [TAG_W-1:0] tag
);
    // Hold the flag and line; a new reservation overrides any clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            tag   <= '0;
        end else if (arm) begin
            armed <= 1'b1;
            tag   <= arm_tag;
        end else if (disarm) begin
            armed <= 1'b0;
        end
    end
endmodule

// File: rtl/resv_issue.sv
// Registers the memory access and the conditional store status.
// Assumes decisions arrive fully resolved from the top.
module resv_issue #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_rd,
    input  logic              do_cond,
    input  logic              cond_pass,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              sc_done,
    output logic              sc_ok,
    output logic              mem_rd,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    // Control outputs: status and access strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_done <= 1'b0;
            sc_ok   <= 1'b0;
            mem_rd  <= 1'b0;
            mem_we  <= 1'b0;
        end else begin
            sc_done <= do_cond;
            sc_ok   <= do_cond && cond_pass;
            mem_rd  <= do_rd;
            mem_we  <= do_cond && cond_pass;
        end
    end

    // Address and data path, captured only when an access is issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (do_rd || do_cond) begin
            mem_addr  <= addr;
            mem_wdata <= wdata;
        end
    end
endmodule

// File: rtl/resv_unit.sv
// Reservation unit for reserve/conditional-store atomics on a snooped bus.
// Assumes snp_* carries only other agents' stores, and that a successful
// conditional store leaves on mem_we as a plain bus write.
module resv_unit #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_OFF_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              sc_done,
    output logic              sc_ok,
    output logic              mem_rd,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    import resv_pkg::*;
    localparam int TAG_W = ADDR_W - LINE_OFF_W;

    resv_op_e         op;
    logic [TAG_W-1:0] resv_tag, cpu_tag, snp_tag;
    logic             resv_valid, cpu_same, snp_same;
    logic             is_resv, is_cond, snoop_kill, cond_pass;

    // Decode the request and resolve the snoop/store race.
    always_comb begin
        op         = resv_op_e'(cpu_op);
        is_resv    = (op == OP_RESV);
        is_cond    = (op == OP_COND);
        snoop_kill = snp_valid && resv_valid && snp_same;
        cond_pass  = is_cond && resv_valid && cpu_same && !snoop_kill;
    end

    resv_line_match #(.ADDR_W(ADDR_W), .LINE_OFF_W(LINE_OFF_W)) u_cpu_match (
        .addr(cpu_addr), .ref_tag(resv_tag), .tag(cpu_tag), .same(cpu_same)
    );

    resv_line_match #(.ADDR_W(ADDR_W), .LINE_OFF_W(LINE_OFF_W)) u_snp_match (
        .addr(snp_addr), .ref_tag(resv_tag), .tag(snp_tag), .same(snp_same)
    );

    resv_slot #(.TAG_W(TAG_W)) u_slot (
        .clk(clk), .rst_n(rst_n),
        .arm(is_resv), .arm_tag(cpu_tag),
        .disarm(is_cond || snoop_kill),
        .armed(resv_valid), .tag(resv_tag)
    );

    resv_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_issue (
        .clk(clk), .rst_n(rst_n),
        .do_rd(is_resv), .do_cond(is_cond), .cond_pass(cond_pass),
        .addr(cpu_addr), .wdata(cpu_wdata),
        .sc_done(sc_done), .sc_ok(sc_ok), .mem_rd(mem_rd), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    logic unused_snp_tag;
    assign unused_snp_tag = ^snp_tag;
endmodule

// File: rtl/resv_unit_chk.sv
// Temporal checks for resv_unit, attached by bind below.
module resv_unit_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_OFF_W = 6,
    localparam int TAG_W     = ADDR_W - LINE_OFF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cpu_op,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              snp_valid,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              sc_done,
    input logic              sc_ok,
    input logic              mem_rd,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              resv_valid,
    input logic [TAG_W-1:0]  resv_tag
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!sc_done && !sc_ok && !mem_we && !mem_rd && !resv_valid));

    a_r2_resv_issues_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_op == 2'd1) |=> (mem_rd && mem_addr == $past(cpu_addr) && resv_valid));

    a_r4_no_resv_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_op == 2'd2 && !resv_valid) |=> (sc_done && !sc_ok && !mem_we));

    a_r7_cond_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_op == 2'd2) |=> !resv_valid);

    a_r8_snoop_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && cpu_op != 2'd1 &&
         snp_addr[ADDR_W-1:LINE_OFF_W] == resv_tag) |=> !resv_valid);

    a_r9_snoop_beats_cond: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_op == 2'd2 && snp_valid &&
         snp_addr[ADDR_W-1:LINE_OFF_W] == cpu_addr[ADDR_W-1:LINE_OFF_W]) |=> !sc_ok);

    a_r12_we_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (sc_ok && sc_done));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_op == 2'd0) |=> (!sc_done && !mem_we && !mem_rd));
endmodule

bind resv_unit resv_unit_chk #(.ADDR_W(ADDR_W), .LINE_OFF_W(LINE_OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .sc_done(sc_done),
    .sc_ok(sc_ok), .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
    .resv_valid(resv_valid), .resv_tag(resv_tag)
);

// File: tb/resv_unit_bench.sv
`timescale 1ns/1ps
module resv_unit_bench;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int OFF    = 6;

    typedef struct {
        string             req;
        logic              done;
        logic              ok;
        logic              rd;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cpu_op = 2'd0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic              snp_valid = 1'b0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              sc_done, sc_ok, mem_rd, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;

    logic                  m_armed = 1'b0;
    logic [ADDR_W-OFF-1:0] m_tag = '0;

    always #5 clk = ~clk;

    resv_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_OFF_W(OFF)) u_resv_unit (
        .clk(clk), .rst_n(rst_n), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .snp_valid(snp_valid), .snp_addr(snp_addr),
        .sc_done(sc_done), .sc_ok(sc_ok), .mem_rd(mem_rd), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    function automatic logic [ADDR_W-OFF-1:0] line_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:OFF];
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Driver: apply one request per cycle and queue the expected result.
    task automatic step(input string req, input logic [1:0] op,
                        input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        input logic sv, input logic [ADDR_W-1:0] sa);
        exp_t e;
        logic kill, pass;
        @(negedge clk);
        cpu_op = op; cpu_addr = a; cpu_wdata = d; snp_valid = sv; snp_addr = sa;
        kill = sv && m_armed && (line_of(sa) == m_tag);
        pass = (op == 2'd2) && m_armed && (line_of(a) == m_tag) && !kill;
        e.req = req; e.done = (op == 2'd2); e.ok = pass; e.we = pass;
        e.rd = (op == 2'd1); e.addr = a; e.data = d;
        exp_q.push_back(e);
        if (op == 2'd1) begin
            m_armed = 1'b1; m_tag = line_of(a);
        end else if (op == 2'd2 || kill) begin
            m_armed = 1'b0;
        end
    endtask

    // Monitor: compare outputs one step after each clock edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, "sc_done", 64'(sc_done), 64'(e.done));
                check(e.req, "sc_ok",   64'(sc_ok),   64'(e.ok));
                check(e.req, "mem_we",  64'(mem_we),  64'(e.we));
                check(e.req, "mem_rd",  64'(mem_rd),  64'(e.rd));
                if (e.rd || e.done) check(e.req, "mem_addr", 64'(mem_addr), 64'(e.addr));
                if (e.we) check(e.req, "mem_wdata", 64'(mem_wdata), 64'(e.data));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog all actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    localparam logic [ADDR_W-1:0] A  = 32'h1000_0040;
    localparam logic [ADDR_W-1:0] A2 = 32'h1000_0078;
    localparam logic [ADDR_W-1:0] B  = 32'h3000_0000;
    localparam logic [ADDR_W-1:0] Z  = 32'h0;

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "sc_done", 64'(sc_done), 64'd0);
        check("R1", "mem_we",  64'(mem_we),  64'd0);
        check("R1", "mem_rd",  64'(mem_rd),  64'd0);
        @(negedge clk); rst_n = 1'b1;

        step("R12", 2'd0, A, 32'h11, 1'b0, Z);
        step("R1",  2'd2, A, 32'h12, 1'b0, Z);            // disarmed after reset
        step("R2",  2'd1, A, 0, 1'b0, Z);
        step("R6",  2'd2, A2, 32'hCAFE_0001, 1'b0, Z);    // same line, other offset
        step("R7",  2'd2, A, 32'h13, 1'b0, Z);            // cleared by prior store
        step("R4",  2'd2, B, 32'h14, 1'b0, Z);
        step("R2",  2'd1, A, 0, 1'b0, Z);
        step("R5",  2'd2, B, 32'h15, 1'b0, Z);
        step("R7",  2'd2, A, 32'h16, 1'b0, Z);            // failed store also cleared
        step("R2",  2'd1, A, 0, 1'b0, Z);
        step("R8",  2'd0, Z, 0, 1'b1, 32'h2000_0000);     // other line: no effect
        step("R3",  2'd2, A, 32'hBEEF_0002, 1'b0, Z);
        step("R2",  2'd1, A, 0, 1'b0, Z);
        step("R8",  2'd0, Z, 0, 1'b1, 32'h1000_0050);     // same line: disarms
        step("R8",  2'd2, A, 32'h17, 1'b0, Z);
        step("R2",  2'd1, A, 0, 1'b0, Z);
        step("R9",  2'd2, A, 32'h18, 1'b1, A2);
        step("R10", 2'd1, A, 0, 1'b1, A);
        step("R10", 2'd2, A, 32'hD00D_0003, 1'b0, Z);
        step("R11", 2'd1, A, 0, 1'b0, Z);
        step("R11", 2'd1, B, 0, 1'b0, Z);
        step("R11", 2'd2, A, 32'h19, 1'b0, Z);
        step("R11", 2'd1, A, 0, 1'b0, Z);
        step("R11", 2'd1, B, 0, 1'b0, Z);
        step("R3",  2'd2, B, 32'hFACE_0004, 1'b0, Z);
        step("R12", 2'd0, B, 0, 1'b0, Z);
        step("R12", 2'd0, Z, 0, 1'b0, Z);
        repeat (3) @(posedge clk);
        #2;
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule